// File: doc/BRIEF.md
# Indirect NVRAM Byte Window

This block puts a byte-wide non-volatile store of up to 8 KiB behind a window of four byte ports. The store is reached indirectly. Two of the ports each load one half of a 16-bit address latch. A third port moves a data byte to or from the latched location. The fourth port is a spare that reads back all ones and ignores writes. The latch returns to zero after every data write, so software that streams bytes must reload the address each time. Reads leave the latch where it is, so one location can be polled over and over.

Two lock bits, loaded through a sideband input with its own strobe, each close one 16-byte window near the bottom of the address space. A closed window reads as all ones and drops writes. Any address at or beyond the configured store size behaves the same way. This keeps accesses meant for the time-of-day registers above the store from reaching the array. A neighbouring block decodes those registers through the same address space.

Read data is registered. It appears on `port_rdata` one clock after the read strobe and holds until the next read strobe.

Top module: `nvram_window`

## Requirements
- R1: A write to port offset 0 replaces bits 7:0 of the address latch and a write to offset 1 replaces bits 15:8; the other half keeps its value.
- R2: A write to port offset 3 stores the data byte at the latched address, then sets the latch to 0x0000, so the next data write lands at address 0.
- R3: A read of port offset 3 returns the byte at the latched address and leaves the latch unchanged, so repeated reads and a following write use the same address.
- R4: Reads of port offsets 0, 1 and 2 return 0xFF; a write to offset 2 changes neither the latch nor the store.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F read as 0xFF and writes to them are dropped; neighbouring addresses are unaffected.
- R6: While lock bit 1 is set, addresses 0x30 to 0x3F read as 0xFF and writes to them are dropped; neighbouring addresses are unaffected.
- R7: A read at or beyond the store size (parameter MEM_BYTES, 0x800 or 0x2000) returns 0xFF, and a write there is dropped without aliasing onto a lower address; the latch still clears after it.
- R8: Reset sets the address latch to 0x0000, clears both lock bits and sets `port_rdata` to 0xFF; stored bytes survive reset.
- R9: The lock bits take the value of `lock_wdata` (bit 0 for the low window, bit 1 for the high window) only in a cycle where `lock_wr` is high.
- R10: `port_rdata` is valid one clock after `port_rd` and holds its value in every cycle without `port_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 2 | Window port offset: 0 address low, 1 address high, 2 spare, 3 data |
| port_wr | input | 1 | Write strobe for the selected port |
| port_rd | input | 1 | Read strobe for the selected port |
| port_wdata | input | 8 | Byte written to the selected port |
| port_rdata | output | 8 | Registered read byte, valid one clock after `port_rd` |
| lock_wr | input | 1 | Strobe that loads the lock bits |
| lock_wdata | input | 2 | New lock bits; bit 0 closes 0x20-0x2F, bit 1 closes 0x30-0x3F |

## Verification
The hardest state to reach from the ports is a latch or lock register that reset has to clear. The latch already clears itself after every data write, so a plain reset test cannot tell a working reset from a missing one. The bench first fills known bytes at address 0, at a nonzero address and inside a lock window. It then leaves the latch pointing elsewhere with both locks set, and asserts reset. The only way for the following reads to return the address-0 byte and the unlocked window byte is for reset to have cleared both registers.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

    // Offsets of the four byte ports in the window.
    typedef enum logic [1:0] {
        OFS_ADDR_LO = 2'd0,
        OFS_ADDR_HI = 2'd1,
        OFS_SPARE   = 2'd2,
        OFS_DATA    = 2'd3
    } port_ofs_e;

    // Lower bound of lock window n, given the first window base and its span.
    function automatic int lock_lo(input int base, input int span, input int n);
        return base + n * span;
    endfunction

endpackage

// File: rtl/nvp_addr_latch.sv
module nvp_addr_latch #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W/BYTE_W-1:0] ld_lane,
    input  logic              clr,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int LANES = ADDR_W / BYTE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < LANES; i++) begin
            if (ld_lane[i]) begin
                state_d.addr[i*BYTE_W +: BYTE_W] = byte_in;
            end
        end
        if (clr) begin
            state_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign addr_q = state_q.addr;

    // A data write leaves the latch at zero.
    assert_clear_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> addr_q == '0);

    // Without a lane load or a data write the latch does not move.
    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_lane == '0) |=> $stable(addr_q));

    // Loading the low lane alone keeps the upper bits.
    assert_low_lane_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ld_lane == LANES'(1)) |=>
            addr_q[ADDR_W-1:BYTE_W] == $past(addr_q[ADDR_W-1:BYTE_W]));

endmodule

// File: rtl/nvp_lock_gate.sv
module nvp_lock_gate #(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 2048,
    parameter int LOCK_N    = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [LOCK_N-1:0] lock_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [LOCK_N-1:0] lock_q,
    output logic              in_range,
    output logic              blocked
);
    import nvp_pkg::*;

    localparam logic [ADDR_W:0] SIZE_L = MEM_BYTES[ADDR_W:0];

    typedef struct packed {
        logic [LOCK_N-1:0] lock;
    } lock_state_t;

    lock_state_t state_d, state_q;
    logic [LOCK_N-1:0] win_hit;

    // One address comparator pair per lock window.
    generate
        for (genvar g = 0; g < LOCK_N; g++) begin : g_win
            localparam int WLO = lock_lo(LOCK_BASE, LOCK_SPAN, g);
            localparam int WHI = lock_lo(LOCK_BASE, LOCK_SPAN, g + 1);
            assign win_hit[g] = (addr >= WLO[ADDR_W-1:0]) && (addr < WHI[ADDR_W-1:0]);
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (lock_wr) begin
            state_d.lock = lock_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lock_q   = state_q.lock;
    assign blocked  = |(win_hit & state_q.lock);
    assign in_range = {1'b0, addr} < SIZE_L;

    // Lock bits change only under the sideband strobe.
    assert_lock_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr |=> $stable(lock_q));

    assert_lock_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> lock_q == $past(lock_in));

endmodule

// File: rtl/nvp_mem_array.sv
module nvp_mem_array #(
    parameter int DEPTH  = 2048,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [BYTE_W-1:0]        rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem_q [DEPTH];

    // Storage is non-volatile: no reset on the array.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    initial begin
        assert_depth_fits_R7: assert (IDX_W > 0 && DEPTH <= (1 << IDX_W))
            else $error("store depth does not fit its index");
    end

endmodule

// File: rtl/nvram_window.sv
module nvram_window #(
    parameter int BYTE_W    = 8,
    parameter int MEM_BYTES = 2048,
    parameter int LOCK_N    = 2,
    parameter int LOCK_BASE = 32,
    parameter int LOCK_SPAN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        port_addr,
    input  logic              port_wr,
    input  logic              port_rd,
    input  logic [BYTE_W-1:0] port_wdata,
    output logic [BYTE_W-1:0] port_rdata,
    input  logic              lock_wr,
    input  logic [LOCK_N-1:0] lock_wdata
);
    import nvp_pkg::*;

    localparam int ADDR_W = 2 * BYTE_W;
    localparam int LANES  = ADDR_W / BYTE_W;
    localparam int IDX_W  = $clog2(MEM_BYTES);

    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_state_t;

    port_ofs_e          ofs;
    logic [LANES-1:0]   ld_lane;
    logic               data_wr;
    logic               data_rd;
    logic [ADDR_W-1:0]  addr_q;
    logic [LOCK_N-1:0]  lock_q;
    logic               in_range;
    logic               blocked;
    logic               access_ok;
    logic               mem_we;
    logic [BYTE_W-1:0]  mem_rdata;
    rd_state_t          state_d, state_q;

    assign ofs = port_ofs_e'(port_addr);

    // Address ports map onto latch lanes by offset.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign ld_lane[g] = port_wr && (port_addr == 2'(g));
        end
    endgenerate

    assign data_wr   = port_wr && (ofs == OFS_DATA);
    assign data_rd   = port_rd && (ofs == OFS_DATA);
    assign access_ok = in_range && !blocked;
    assign mem_we    = data_wr && access_ok;

    nvp_addr_latch #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lane (ld_lane),
        .clr     (data_wr),
        .byte_in (port_wdata),
        .addr_q  (addr_q)
    );

    nvp_lock_gate #(
        .ADDR_W    (ADDR_W),
        .MEM_BYTES (MEM_BYTES),
        .LOCK_N    (LOCK_N),
        .LOCK_BASE (LOCK_BASE),
        .LOCK_SPAN (LOCK_SPAN)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_wr  (lock_wr),
        .lock_in  (lock_wdata),
        .addr     (addr_q),
        .lock_q   (lock_q),
        .in_range (in_range),
        .blocked  (blocked)
    );

    nvp_mem_array #(
        .DEPTH  (MEM_BYTES),
        .BYTE_W (BYTE_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr_q[IDX_W-1:0]),
        .wdata (port_wdata),
        .raddr (addr_q[IDX_W-1:0]),
        .rdata (mem_rdata)
    );

    always_comb begin
        state_d = state_q;
        if (port_rd) begin
            state_d.rdata = (data_rd && access_ok) ? mem_rdata : '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.rdata <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign port_rdata = state_q.rdata;

    // Non-data ports read back all ones.
    assert_spare_reads_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_addr != 2'd3) |=> port_rdata == '1);

    // A closed lock window reads as all ones.
    assert_locked_read_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_addr == 2'd3 && blocked) |=> port_rdata == '1);

    // An address past the store reads as all ones.
    assert_range_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && port_addr == 2'd3 && !in_range) |=> port_rdata == '1);

    // Read data holds between read strobes.
    assert_rdata_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd |=> $stable(port_rdata));

    // Lock bits only come out of reset cleared.
    assert_locks_clear_after_reset_R8: assert property (@(posedge clk)
        !rst_n |=> lock_q == '0);

endmodule

// File: tb/nvram_window_test.sv
module nvram_window_test;

    localparam int MEM_BYTES = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] port_addr = 2'd0;
    logic       port_wr = 1'b0;
    logic       port_rd = 1'b0;
    logic [7:0] port_wdata = 8'h00;
    logic [7:0] port_rdata;
    logic       lock_wr = 1'b0;
    logic [1:0] lock_wdata = 2'b00;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nvram_window #(.MEM_BYTES(MEM_BYTES)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_addr  (port_addr),
        .port_wr    (port_wr),
        .port_rd    (port_rd),
        .port_wdata (port_wdata),
        .port_rdata (port_rdata),
        .lock_wr    (lock_wr),
        .lock_wdata (lock_wdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // All drivers change at the falling edge; results are sampled there too.
    task automatic port_write(input logic [1:0] o, input logic [7:0] d);
        port_addr = o; port_wdata = d; port_wr = 1'b1;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic port_read(input logic [1:0] o, output logic [7:0] d);
        port_addr = o; port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
        d = port_rdata;
    endtask

    task automatic set_addr(input logic [15:0] a);
        port_write(2'd0, a[7:0]);
        port_write(2'd1, a[15:8]);
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        set_addr(a);
        port_write(2'd3, d);
    endtask

    task automatic peek(input logic [15:0] a, output logic [7:0] d);
        set_addr(a);
        port_read(2'd3, d);
    endtask

    task automatic set_locks(input logic [1:0] v);
        lock_wdata = v; lock_wr = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] d;
        poke(16'h0000, 8'h11);
        poke(16'h0005, 8'h55);
        poke(16'h0020, 8'h22);
        set_addr(16'h0005);
        set_locks(2'b11);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 rdata after reset", port_rdata, 8'hFF);
        port_read(2'd3, d);
        check("R8 latch cleared by reset", d, 8'h11);
        peek(16'h0020, d);
        check("R8 locks cleared by reset", d, 8'h22);
    endtask

    task automatic test_addr_lanes();
        logic [7:0] d;
        poke(16'h0134, 8'h9C);
        poke(16'h0135, 8'h77);
        poke(16'h0234, 8'h42);
        peek(16'h0134, d);
        check("R1 full address load", d, 8'h9C);
        set_addr(16'h0134);
        port_write(2'd0, 8'h35);
        port_read(2'd3, d);
        check("R1 low byte replaced", d, 8'h77);
        set_addr(16'h0134);
        port_write(2'd1, 8'h02);
        port_read(2'd3, d);
        check("R1 high byte replaced", d, 8'h42);
    endtask

    task automatic test_data_write();
        logic [7:0] d;
        set_addr(16'h0100);
        port_write(2'd3, 8'h3C);
        port_write(2'd3, 8'hC3);
        peek(16'h0100, d);
        check("R2 first write at latch", d, 8'h3C);
        peek(16'h0000, d);
        check("R2 second write at zero", d, 8'hC3);
    endtask

    task automatic test_read_hold();
        logic [7:0] d;
        poke(16'h0200, 8'h5A);
        set_addr(16'h0200);
        port_read(2'd3, d);
        check("R3 first read", d, 8'h5A);
        port_read(2'd3, d);
        check("R3 repeat read same address", d, 8'h5A);
        port_write(2'd3, 8'h66);
        peek(16'h0200, d);
        check("R3 write after read same address", d, 8'h66);
    endtask

    task automatic test_spare();
        logic [7:0] d;
        poke(16'h0210, 8'h81);
        set_addr(16'h0210);
        for (int o = 0; o < 3; o++) begin
            port_read(2'(o), d);
            check("R4 non-data port read", d, 8'hFF);
        end
        port_write(2'd2, 8'h00);
        port_read(2'd3, d);
        check("R4 spare write no effect", d, 8'h81);
    endtask

    task automatic test_lock_low();
        logic [7:0] d;
        poke(16'h001F, 8'h1F);
        poke(16'h0020, 8'hA0);
        poke(16'h002F, 8'hAF);
        poke(16'h0030, 8'hB0);
        set_locks(2'b01);
        peek(16'h0020, d); check("R5 window start blocked", d, 8'hFF);
        peek(16'h002F, d); check("R5 window end blocked", d, 8'hFF);
        peek(16'h001F, d); check("R5 below window open", d, 8'h1F);
        peek(16'h0030, d); check("R5 above window open", d, 8'hB0);
        poke(16'h002F, 8'h00);
        set_locks(2'b00);
        peek(16'h002F, d); check("R5 locked write dropped", d, 8'hAF);
    endtask

    task automatic test_lock_high();
        logic [7:0] d;
        poke(16'h003F, 8'hBF);
        poke(16'h0040, 8'hC0);
        set_locks(2'b10);
        peek(16'h0030, d); check("R6 window start blocked", d, 8'hFF);
        peek(16'h003F, d); check("R6 window end blocked", d, 8'hFF);
        peek(16'h002F, d); check("R6 below window open", d, 8'hAF);
        peek(16'h0040, d); check("R6 above window open", d, 8'hC0);
        poke(16'h0030, 8'h00);
        set_locks(2'b00);
        peek(16'h0030, d); check("R6 locked write dropped", d, 8'hB0);
    endtask

    task automatic test_range();
        logic [7:0] d;
        poke(16'h07FF, 8'h7E);
        peek(16'h07FF, d); check("R7 last byte in range", d, 8'h7E);
        peek(16'h0800, d); check("R7 first address past size", d, 8'hFF);
        peek(16'hFFFF, d); check("R7 top address", d, 8'hFF);
        poke(16'h0805, 8'hEE);
        peek(16'h0005, d); check("R7 no alias of dropped write", d, 8'h55);
        poke(16'h0805, 8'hEE);
        port_write(2'd3, 8'hD0);
        peek(16'h0000, d); check("R7 latch clears after dropped write", d, 8'hD0);
    endtask

    task automatic test_lock_strobe();
        logic [7:0] d;
        lock_wdata = 2'b11;
        repeat (3) @(negedge clk);
        peek(16'h0020, d); check("R9 no strobe no lock", d, 8'hA0);
        set_locks(2'b11);
        peek(16'h0020, d); check("R9 strobe locks low", d, 8'hFF);
        peek(16'h003F, d); check("R9 strobe locks high", d, 8'hFF);
        lock_wdata = 2'b00;
        repeat (3) @(negedge clk);
        peek(16'h0020, d); check("R9 no strobe stays locked", d, 8'hFF);
        set_locks(2'b00);
        peek(16'h0020, d); check("R9 strobe unlocks", d, 8'hA0);
    endtask

    task automatic test_rdata_hold();
        logic [7:0] d;
        peek(16'h0200, d);
        check("R10 read one clock after strobe", d, 8'h66);
        repeat (3) @(negedge clk);
        check("R10 idle hold", port_rdata, 8'h66);
        set_addr(16'h0101);
        port_write(2'd3, 8'h12);
        port_write(2'd2, 8'h34);
        check("R10 hold across writes", port_rdata, 8'h66);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_addr_lanes();
        test_data_write();
        test_read_hold();
        test_spare();
        test_lock_low();
        test_lock_high();
        test_range();
        test_lock_strobe();
        test_rdata_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule